// File: doc/BRIEF.md
# USB Host Controller Control and Status Register Block

This block is a word-addressed 32-bit register file that sits beside a USB host controller. It holds the controller's static configuration and drives each setting out as a dedicated output pin. The settings are a four-bit bus filter bypass, five port option flags, a six-bit frame length adjust, byte order select, coherency select, bus master enable, a fully writable 32-bit extension word and a slave-error enable. The block does not act on any of these settings itself.

An interrupt unit collects two error sources: an address decode error (status bit 0) and a host system error (status bit 1). A status bit is set by a one-cycle hardware pulse, and software clears it by writing a one. The mask can only be read over the bus. Software changes it indirectly, through an unmask register that clears mask bits and a mask-set register that sets them. A single registered level output is high while any status bit is set and not masked.

Bus accesses outside the map, and accesses that are not word aligned, read as zero and change nothing. When slave errors are enabled, such an access also returns an error response and latches the address decode error.

Top module: `usb_host_ctl_regs`

## Requirements
- R1: After a synchronous reset:
  - frame adjust reads 0x20 and bus master enable reads 1;
  - the mask reads 0x3;
  - every other register and configuration output is 0;
  - `irq` is low.
- R2: The configuration registers store written data and read it back. Bits outside a register's field ignore writes and read as zero. The layout is:
  - 0x30: bypass in bits [3:0].
  - 0x34: port flags in bits [4:0], where bit 0 is permanent attach, bit 1 is power-control present, bit 2 is MSI enable, bit 3 is command-register write enable and bit 4 is base-address write enable.
  - 0x38: frame adjust in bits [5:0].
  - 0x40, 0x44, 0x48 and 0x60: byte order, coherency, bus master enable and slave-error enable, each in bit 0.
  - 0x78: all 32 bits writable.
- R3: Writing status at 0x64 clears each bit where the data is 1 and leaves each bit where the data is 0. Bit 0 is the address decode error and bit 1 is the host system error.
- R4: A one-cycle pulse on `ev_decode_err` sets status bit 0, and a pulse on `ev_host_err` sets status bit 1. When a pulse and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R5: A write to the mask at 0x68 leaves the mask unchanged.
- R6: Writing the unmask register at 0x6C clears the mask bits where the data is 1. Writing the mask-set register at 0x70 sets the mask bits where the data is 1. Both registers read as zero.
- R7: `irq` equals OR(status AND NOT mask), registered. It changes one clock after the state change that causes it.
- R8: An access to an unmapped or non-word-aligned address changes no register and returns read data 0.
  - With slave-error enable at 1, the access returns `bus_err` = 1 and sets status bit 0.
  - With slave-error enable at 0, `bus_err` stays 0 and status is untouched.
- R9: A request sampled at a clock edge produces `bus_ack` for exactly one cycle after that edge, together with `bus_rdata` and `bus_err`. The register contents change at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | Access completion |
| bus_err | output | 1 | Slave-error response, valid with `bus_ack` |
| ev_decode_err | input | 1 | Hardware set pulse for status bit 0 |
| ev_host_err | input | 1 | Hardware set pulse for status bit 1 |
| filt_bypass | output | 4 | Bus filter bypass field |
| hub_perm_attach | output | 1 | Port flag, bit 0 |
| pwr_ctrl_present | output | 1 | Port flag, bit 1 |
| msi_enable | output | 1 | Port flag, bit 2 |
| cmdreg_wr_en | output | 1 | Port flag, bit 3 |
| bar_wr_en | output | 1 | Port flag, bit 4 |
| frame_adj | output | 6 | Frame length adjust |
| big_endian | output | 1 | Byte order select |
| coherent | output | 1 | Coherency select |
| bus_master_en | output | 1 | Bus master enable |
| usb3_cfg | output | 32 | Extension word |
| irq | output | 1 | Level interrupt |

## Verification
Two functions can land on the same status bit in the same clock cycle: a hardware set pulse and a write-one-to-clear from the bus. The bench provokes this by raising `ev_host_err` in the very cycle that carries a status write of 0x2. It then reads status back and expects bit 1 still set.

A second collision comes from the bus alone. With slave errors enabled, a stray unmapped access sets status bit 0 through the decode-error path, and the bench checks that the bit appears only under that enable.

// File: rtl/usbcr_pkg.sv
package usbcr_pkg;

    localparam int DW      = 32;
    localparam int NUM_SRC = 2;

    localparam int BYP_W  = 4;
    localparam int PORT_W = 5;
    localparam int FADJ_W = 6;

    localparam logic [FADJ_W-1:0]  FADJ_RST = 6'h20;
    localparam logic               BME_RST  = 1'b1;
    localparam logic [NUM_SRC-1:0] MASK_RST = '1;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_FILT,
        SEL_PORT,
        SEL_FADJ,
        SEL_ENDIAN,
        SEL_COHER,
        SEL_BME,
        SEL_RCTL,
        SEL_STAT,
        SEL_MASK,
        SEL_UNMASK,
        SEL_SETMASK,
        SEL_EXT
    } reg_sel_e;

    typedef struct packed {
        logic [BYP_W-1:0]  filt_bypass;
        logic [PORT_W-1:0] port;
        logic [FADJ_W-1:0] frame_adj;
        logic              big_endian;
        logic              coherent;
        logic              bus_master;
        logic              slverr_en;
        logic [DW-1:0]     ext;
    } cfg_t;

    function automatic reg_sel_e decode_off(input logic [31:0] off);
        case (off)
            32'h30:  return SEL_FILT;
            32'h34:  return SEL_PORT;
            32'h38:  return SEL_FADJ;
            32'h40:  return SEL_ENDIAN;
            32'h44:  return SEL_COHER;
            32'h48:  return SEL_BME;
            32'h60:  return SEL_RCTL;
            32'h64:  return SEL_STAT;
            32'h68:  return SEL_MASK;
            32'h6C:  return SEL_UNMASK;
            32'h70:  return SEL_SETMASK;
            32'h78:  return SEL_EXT;
            default: return SEL_NONE;
        endcase
    endfunction

    function automatic cfg_t cfg_reset();
        cfg_t c;
        c            = '0;
        c.frame_adj  = FADJ_RST;
        c.bus_master = BME_RST;
        return c;
    endfunction

endpackage

// File: rtl/usbcr_decode.sv
module usbcr_decode
    import usbcr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic              hit
);
    localparam int PAD_W = 32 - ADDR_W;

    logic [31:0] off;
    logic        aligned;

    generate
        if (PAD_W > 0) begin : g_pad
            assign off = {{PAD_W{1'b0}}, addr};
        end else begin : g_trunc
            assign off = addr[31:0];
        end
    endgenerate

    assign aligned = (addr[1:0] == 2'b00);

    always_comb begin
        sel = aligned ? decode_off(off) : SEL_NONE;
        hit = (sel != SEL_NONE);
    end
endmodule

// File: rtl/usbcr_cfg.sv
module usbcr_cfg
    import usbcr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  reg_sel_e      sel,
    input  logic [DW-1:0] wdata,
    output cfg_t          cfg
);
    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= cfg_reset();
        end else if (wr_en) begin
            case (sel)
                SEL_FILT:   cfg_q.filt_bypass <= wdata[BYP_W-1:0];
                SEL_PORT:   cfg_q.port        <= wdata[PORT_W-1:0];
                SEL_FADJ:   cfg_q.frame_adj   <= wdata[FADJ_W-1:0];
                SEL_ENDIAN: cfg_q.big_endian  <= wdata[0];
                SEL_COHER:  cfg_q.coherent    <= wdata[0];
                SEL_BME:    cfg_q.bus_master  <= wdata[0];
                SEL_RCTL:   cfg_q.slverr_en   <= wdata[0];
                SEL_EXT:    cfg_q.ext         <= wdata;
                default:    ;
            endcase
        end
    end

    assign cfg = cfg_q;

    // R2: configuration is held whenever no write is presented
    a_r2_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cfg_q))
        else $error("a_r2_cfg_hold");
endmodule

// File: rtl/usbcr_irq.sv
module usbcr_irq
    import usbcr_pkg::*;
#(
    parameter int NSRC = NUM_SRC
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] hw_set,
    input  logic            clr_wr,
    input  logic            en_wr,
    input  logic            dis_wr,
    input  logic [NSRC-1:0] wdata,
    output logic [NSRC-1:0] status,
    output logic [NSRC-1:0] mask,
    output logic            irq
);
    logic [NSRC-1:0] status_q;
    logic [NSRC-1:0] mask_q;
    logic            irq_q;

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_src
            always_ff @(posedge clk) begin
                if (rst) begin
                    status_q[i] <= 1'b0;
                end else if (hw_set[i]) begin
                    status_q[i] <= 1'b1;
                end else if (clr_wr && wdata[i]) begin
                    status_q[i] <= 1'b0;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    mask_q[i] <= MASK_RST[i];
                end else if (en_wr && wdata[i]) begin
                    mask_q[i] <= 1'b0;
                end else if (dis_wr && wdata[i]) begin
                    mask_q[i] <= 1'b1;
                end
            end

            // R4: a set pulse always leaves the bit set, even against a clear
            a_r4_set_wins: assert property (@(posedge clk) disable iff (rst)
                hw_set[i] |=> status_q[i])
                else $error("a_r4_set_wins");

            // R3: clear without a competing set empties the bit
            a_r3_w1c_clears: assert property (@(posedge clk) disable iff (rst)
                (clr_wr && wdata[i] && !hw_set[i]) |=> !status_q[i])
                else $error("a_r3_w1c_clears");

            // R6: unmask clears, mask-set sets
            a_r6_unmask_clears: assert property (@(posedge clk) disable iff (rst)
                (en_wr && wdata[i]) |=> !mask_q[i])
                else $error("a_r6_unmask_clears");

            a_r6_setmask_sets: assert property (@(posedge clk) disable iff (rst)
                (dis_wr && wdata[i]) |=> mask_q[i])
                else $error("a_r6_setmask_sets");
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(status_q & ~mask_q);
        end
    end

    assign status = status_q;
    assign mask   = mask_q;
    assign irq    = irq_q;

    // R5: the mask moves only through the unmask and mask-set commands
    a_r5_mask_holds: assert property (@(posedge clk) disable iff (rst)
        (!en_wr && !dis_wr) |=> $stable(mask_q))
        else $error("a_r5_mask_holds");

    // R7: a fully masked unit keeps the interrupt low on the next cycle
    a_r7_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (&mask_q) |=> !irq_q)
        else $error("a_r7_masked_quiet");
endmodule

// File: rtl/usb_host_ctl_regs.sv
module usb_host_ctl_regs
    import usbcr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_ack,
    output logic              bus_err,
    input  logic              ev_decode_err,
    input  logic              ev_host_err,
    output logic [3:0]        filt_bypass,
    output logic              hub_perm_attach,
    output logic              pwr_ctrl_present,
    output logic              msi_enable,
    output logic              cmdreg_wr_en,
    output logic              bar_wr_en,
    output logic [5:0]        frame_adj,
    output logic              big_endian,
    output logic              coherent,
    output logic              bus_master_en,
    output logic [31:0]       usb3_cfg,
    output logic              irq
);
    reg_sel_e         sel;
    logic             hit;
    cfg_t             cfg;
    logic             wr_go;
    logic             miss_err;
    logic [NUM_SRC-1:0] hw_set;
    logic [NUM_SRC-1:0] status;
    logic [NUM_SRC-1:0] mask;
    logic [DW-1:0]    rd_val;

    logic [DW-1:0]    rdata_q;
    logic             ack_q;
    logic             err_q;

    usbcr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel),
        .hit  (hit)
    );

    assign wr_go    = bus_req && bus_we && hit;
    assign miss_err = bus_req && !hit && cfg.slverr_en;
    assign hw_set   = {ev_host_err, ev_decode_err | miss_err};

    usbcr_cfg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_go),
        .sel   (sel),
        .wdata (bus_wdata),
        .cfg   (cfg)
    );

    usbcr_irq #(.NSRC(NUM_SRC)) u_irq (
        .clk    (clk),
        .rst    (rst),
        .hw_set (hw_set),
        .clr_wr (wr_go && sel == SEL_STAT),
        .en_wr  (wr_go && sel == SEL_UNMASK),
        .dis_wr (wr_go && sel == SEL_SETMASK),
        .wdata  (bus_wdata[NUM_SRC-1:0]),
        .status (status),
        .mask   (mask),
        .irq    (irq)
    );

    always_comb begin
        rd_val = '0;
        case (sel)
            SEL_FILT:   rd_val[BYP_W-1:0]   = cfg.filt_bypass;
            SEL_PORT:   rd_val[PORT_W-1:0]  = cfg.port;
            SEL_FADJ:   rd_val[FADJ_W-1:0]  = cfg.frame_adj;
            SEL_ENDIAN: rd_val[0]           = cfg.big_endian;
            SEL_COHER:  rd_val[0]           = cfg.coherent;
            SEL_BME:    rd_val[0]           = cfg.bus_master;
            SEL_RCTL:   rd_val[0]           = cfg.slverr_en;
            SEL_STAT:   rd_val[NUM_SRC-1:0] = status;
            SEL_MASK:   rd_val[NUM_SRC-1:0] = mask;
            SEL_EXT:    rd_val              = cfg.ext;
            default:    rd_val              = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q   <= 1'b0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            ack_q   <= bus_req;
            err_q   <= miss_err;
            rdata_q <= (bus_req && !bus_we) ? rd_val : '0;
        end
    end

    assign bus_ack   = ack_q;
    assign bus_err   = err_q;
    assign bus_rdata = rdata_q;

    assign filt_bypass      = cfg.filt_bypass;
    assign hub_perm_attach  = cfg.port[0];
    assign pwr_ctrl_present = cfg.port[1];
    assign msi_enable       = cfg.port[2];
    assign cmdreg_wr_en     = cfg.port[3];
    assign bar_wr_en        = cfg.port[4];
    assign frame_adj        = cfg.frame_adj;
    assign big_endian       = cfg.big_endian;
    assign coherent         = cfg.coherent;
    assign bus_master_en    = cfg.bus_master;
    assign usb3_cfg         = cfg.ext;

    // R9: every request is answered on the next cycle
    a_r9_ack_after_req: assert property (@(posedge clk) disable iff (rst)
        bus_req |=> bus_ack)
        else $error("a_r9_ack_after_req");

    a_r9_no_stray_ack: assert property (@(posedge clk) disable iff (rst)
        !bus_req |=> !bus_ack)
        else $error("a_r9_no_stray_ack");

    // R8: an error response only comes with an acknowledge
    a_r8_err_with_ack: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> bus_ack)
        else $error("a_r8_err_with_ack");
endmodule

// File: tb/tb_usb_host_ctl_regs.sv
module tb_usb_host_ctl_regs;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_req = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_ack;
    logic              bus_err;
    logic              ev_decode_err = 1'b0;
    logic              ev_host_err = 1'b0;
    logic [3:0]        filt_bypass;
    logic              hub_perm_attach, pwr_ctrl_present, msi_enable;
    logic              cmdreg_wr_en, bar_wr_en;
    logic [5:0]        frame_adj;
    logic              big_endian, coherent, bus_master_en;
    logic [31:0]       usb3_cfg;
    logic              irq;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_host_ctl_regs #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst(rst),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .bus_err(bus_err),
        .ev_decode_err(ev_decode_err), .ev_host_err(ev_host_err),
        .filt_bypass(filt_bypass), .hub_perm_attach(hub_perm_attach),
        .pwr_ctrl_present(pwr_ctrl_present), .msi_enable(msi_enable),
        .cmdreg_wr_en(cmdreg_wr_en), .bar_wr_en(bar_wr_en),
        .frame_adj(frame_adj), .big_endian(big_endian), .coherent(coherent),
        .bus_master_en(bus_master_en), .usb3_cfg(usb3_cfg), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // one access; returns at the negedge after the answering edge
    task automatic bus_op(input logic we, input logic [7:0] addr, input logic [31:0] wd,
                          output logic [31:0] rd, output logic ack, output logic err);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = addr; bus_wdata = wd;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        rd = bus_rdata; ack = bus_ack; err = bus_err;
    endtask

    task automatic wr(input logic [7:0] addr, input logic [31:0] wd);
        logic [31:0] rd; logic a, e;
        bus_op(1'b1, addr, wd, rd, a, e);
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] addr, input logic [31:0] exp);
        logic [31:0] rd; logic a, e;
        bus_op(1'b0, addr, 32'h0, rd, a, e);
        chk(tag, rd, exp);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 irq low", {31'b0, irq}, 32'h0);
        chk("R1 frame_adj out", {26'b0, frame_adj}, 32'h20);
        chk("R1 bme out", {31'b0, bus_master_en}, 32'h1);
        rd_chk("R1 frame adjust reg", 8'h38, 32'h20);
        rd_chk("R1 bme reg", 8'h48, 32'h1);
        rd_chk("R1 mask reg", 8'h68, 32'h3);
        rd_chk("R1 status reg", 8'h64, 32'h0);
        rd_chk("R1 port reg", 8'h34, 32'h0);
        rd_chk("R1 ext reg", 8'h78, 32'h0);
    endtask

    task automatic t_cfg_rw();
        logic [31:0] rd; logic a, e;
        do_reset();
        wr(8'h30, 32'hFFFF_FFFF);
        chk("R2 bypass out", {28'b0, filt_bypass}, 32'hF);
        rd_chk("R2 bypass reserved", 8'h30, 32'hF);
        wr(8'h34, 32'hFFFF_FFF5);
        chk("R2 port flags out",
            {27'b0, bar_wr_en, cmdreg_wr_en, msi_enable, pwr_ctrl_present, hub_perm_attach},
            32'h15);
        rd_chk("R2 port reserved", 8'h34, 32'h15);
        wr(8'h38, 32'hABCD_EF3A);
        chk("R2 frame adj out", {26'b0, frame_adj}, 32'h3A);
        wr(8'h40, 32'hFFFF_FFFF);
        wr(8'h44, 32'h0000_0003);
        wr(8'h48, 32'h0000_0002);
        chk("R2 endian/coh/bme", {29'b0, big_endian, coherent, bus_master_en}, 32'h6);
        rd_chk("R2 endian reserved", 8'h40, 32'h1);
        wr(8'h78, 32'hDEAD_BEEF);
        chk("R2 ext out", usb3_cfg, 32'hDEAD_BEEF);
        bus_op(1'b0, 8'h78, 32'h0, rd, a, e);
        chk("R2 ext read", rd, 32'hDEAD_BEEF);
        chk("R9 ack on read", {31'b0, a}, 32'h1);
        chk("R9 no err mapped", {31'b0, e}, 32'h0);
        @(negedge clk);
        chk("R9 ack one cycle", {31'b0, bus_ack}, 32'h0);
    endtask

    task automatic pulse(input bit dec, input bit host);
        @(negedge clk);
        ev_decode_err = dec; ev_host_err = host;
        @(negedge clk);
        ev_decode_err = 1'b0; ev_host_err = 1'b0;
    endtask

    task automatic t_status();
        do_reset();
        pulse(1'b1, 1'b0);
        rd_chk("R4 decode pulse sets bit0", 8'h64, 32'h1);
        pulse(1'b0, 1'b1);
        rd_chk("R4 host pulse sets bit1", 8'h64, 32'h3);
        wr(8'h64, 32'h0);
        rd_chk("R3 write zero keeps", 8'h64, 32'h3);
        wr(8'h64, 32'h1);
        rd_chk("R3 w1c bit0", 8'h64, 32'h2);
        // collision: clear bit1 in the same cycle as a host error pulse
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 8'h64; bus_wdata = 32'h2;
        ev_host_err = 1'b1;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0; ev_host_err = 1'b0;
        rd_chk("R4 set wins over clear", 8'h64, 32'h2);
        wr(8'h64, 32'hFFFF_FFFF);
        rd_chk("R3 w1c all", 8'h64, 32'h0);
    endtask

    task automatic t_mask_irq();
        do_reset();
        wr(8'h68, 32'h0);
        rd_chk("R5 mask read-only", 8'h68, 32'h3);
        pulse(1'b0, 1'b1);
        @(negedge clk);
        chk("R7 masked no irq", {31'b0, irq}, 32'h0);
        wr(8'h6C, 32'h2);
        chk("R7 irq not before next edge", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk("R7 irq after unmask", {31'b0, irq}, 32'h1);
        rd_chk("R6 unmask cleared bit1", 8'h68, 32'h1);
        rd_chk("R6 unmask reads zero", 8'h6C, 32'h0);
        wr(8'h70, 32'h2);
        @(negedge clk);
        chk("R7 irq drops after mask-set", {31'b0, irq}, 32'h0);
        rd_chk("R6 mask-set set bit1", 8'h68, 32'h3);
        rd_chk("R6 mask-set reads zero", 8'h70, 32'h0);
        wr(8'h6C, 32'h3);
        @(negedge clk);
        chk("R7 irq on again", {31'b0, irq}, 32'h1);
        wr(8'h64, 32'h2);
        @(negedge clk);
        chk("R7 irq drops after clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] rd; logic a, e;
        do_reset();
        wr(8'h30, 32'h5);
        bus_op(1'b0, 8'h50, 32'h0, rd, a, e);
        chk("R8 unmapped read zero", rd, 32'h0);
        chk("R8 no err when disabled", {31'b0, e}, 32'h0);
        bus_op(1'b1, 8'h31, 32'hF, rd, a, e);
        chk("R8 misaligned no err disabled", {31'b0, e}, 32'h0);
        rd_chk("R8 status untouched disabled", 8'h64, 32'h0);
        wr(8'h60, 32'h1);
        bus_op(1'b0, 8'h7C, 32'h0, rd, a, e);
        chk("R8 unmapped err enabled", {31'b0, e}, 32'h1);
        chk("R8 unmapped read zero enabled", rd, 32'h0);
        chk("R9 ack with err", {31'b0, a}, 32'h1);
        rd_chk("R8 decode status set", 8'h64, 32'h1);
        bus_op(1'b1, 8'h32, 32'hA, rd, a, e);
        chk("R8 misaligned err", {31'b0, e}, 32'h1);
        rd_chk("R8 misaligned write ignored", 8'h30, 32'h5);
        bus_op(1'b1, 8'hF0, 32'hA, rd, a, e);
        chk("R8 beyond map err", {31'b0, e}, 32'h1);
    endtask

    initial begin
        t_reset();
        t_cfg_rw();
        t_status();
        t_mask_irq();
        t_unmapped();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule